// File: doc/BRIEF.md
# Restoring Sequential Divider

A multi-cycle integer divider built around the restoring method. A pulse on `start` captures a dividend, a divisor and a mode bit. In unsigned mode both operands are plain binary. In signed mode both are two's complement. The divider turns signed operands into magnitudes and then runs one trial subtraction per quotient bit. Each trial shifts the partial remainder left and subtracts the divisor magnitude. A non-negative difference is kept and yields quotient bit 1. A negative difference is discarded, the old remainder is kept, and the quotient bit is 0.

One 2W-bit accumulator holds the partial remainder in its upper half. The lower half starts out holding the dividend magnitude. It fills with quotient bits as the dividend bits are shifted out, so no separate quotient register exists. After the last step a finish cycle applies the sign rules and loads the registered outputs. The quotient is negated when the operand signs differ. The remainder takes the sign of the dividend.

The parameter `UNROLL` sets how many trial steps are chained within one clock, which trades logic depth against latency. Division by zero is not trapped. It runs for the normal number of cycles and raises a flag next to a defined result.

Top module: `restoring_divider`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: In unsigned mode (`signed_mode`=0) with a non-zero divisor, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor, so dividend = quotient*divisor + remainder and remainder < divisor.
- R3: In signed mode (`signed_mode`=1) with a non-zero divisor, the operands are read as two's complement. The quotient is the magnitude quotient truncated toward zero, and it is negated when the dividend sign bit differs from the divisor sign bit.
- R4: In signed mode with a non-zero divisor, the remainder is zero or carries the sign of the dividend, its magnitude is below that of the divisor, and dividend = quotient*divisor + remainder.
- R5: In signed mode the most negative dividend divided by all-ones (-1) gives `quotient` equal to the most negative value (bit W-1 set, the other bits clear) and `remainder` zero.
- R6: A zero divisor completes with normal timing. It sets `div_by_zero`=1 and makes `remainder` equal to the dividend. The quotient magnitude is all ones, so `quotient` is all ones except in signed mode with a negative dividend, where it is 1. Any non-zero divisor leaves `div_by_zero`=0.
- R7: `start` is accepted on a rising edge where `busy` is 0. `busy` is 1 after that edge. `done` is 1 after rising edge number W/UNROLL+2, counting the accepting edge as number 1. `done` lasts exactly one cycle, and `busy` is already 0 in that cycle.
- R8: `start` is ignored while `busy` is 1: the operands and mode presented then change neither the result nor the timing of the operation in progress.
- R9: `quotient`, `remainder` and `div_by_zero` change only on the edge that raises `done`, and they hold their values until the next such edge.
- R10: `start` presented in the cycle where `done` is 1 is accepted, so back-to-back operations need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; sampled only when not busy |
| signed_mode | input | 1 | 1 selects two's complement operands and results |
| dividend | input | W | Dividend, captured with start |
| divisor | input | W | Divisor, captured with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking valid new results |
| quotient | output | W | Registered quotient |
| remainder | output | W | Registered remainder |
| div_by_zero | output | 1 | Registered flag: the last completed operation had a zero divisor |

## Verification
Two functions can fall in the same cycle. The done pulse that ends one operation can coincide with a start request for the next operation. A start can also arrive in the finish cycle, when busy is still high. The bench provokes the first case by raising start in the cycle where done is seen. It checks that the finished result is correct in that cycle, that busy rises on the following edge, and that the second operation returns its own correct result with full latency. The bench provokes the second case by pulsing start with different operands in the middle of a run. It checks that the running operation's result and its latency are unchanged, and that the outputs keep the previous result until the next done.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_magnitude.sv
// Converts an operand to its magnitude and reports whether it was negative.
module div_magnitude #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic [W-1:0] value,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = signed_mode & value[W-1];
    mag = neg ? (~value + 1'b1) : value;
  end
endmodule

// File: rtl/div_restore_step.sv
// One restoring step: shift left, trial subtract, keep or restore.
module div_restore_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] acc_o
);
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         below;
  logic [W-1:0] upper_next;

  always_comb begin
    // partial remainder doubled, next dividend bit appended; needs W+1 bits
    shifted    = {acc_i[2*W-1:W], acc_i[W-1]};
    trial      = {1'b0, shifted} - {2'b00, dvs_i};
    below      = trial[W+1];
    // restore keeps the shifted value, which is then smaller than the divisor
    upper_next = below ? shifted[W-1:0] : trial[W-1:0];
    acc_o      = {upper_next, acc_i[W-2:0], ~below};
  end
endmodule

// File: rtl/div_sign_fix.sv
// Applies the sign rules to the magnitude results.
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         q_neg,
  input  logic         r_neg,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);
  always_comb begin
    q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
    r_out = r_neg ? (~r_mag + 1'b1) : r_mag;
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W      = 32,
  parameter int UNROLL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  import div_pkg::*;

  localparam int ITER = W / UNROLL;
  localparam int CW   = $clog2(ITER + 1);
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  div_state_e     state;
  logic [CW-1:0]  step_cnt;
  logic [2*W-1:0] acc;
  logic [W-1:0]   dvs_mag;
  logic           q_neg_r;
  logic           r_neg_r;
  logic           dz_r;

  logic [W-1:0]   dvd_mag_c;
  logic [W-1:0]   dvs_mag_c;
  logic           dvd_neg_c;
  logic           dvs_neg_c;
  logic [W-1:0]   q_fix;
  logic [W-1:0]   r_fix;
  logic [2*W-1:0] chain [UNROLL+1];

  div_magnitude #(.W(W)) u_mag_dvd (
    .signed_mode(signed_mode), .value(dividend), .mag(dvd_mag_c), .neg(dvd_neg_c)
  );
  div_magnitude #(.W(W)) u_mag_dvs (
    .signed_mode(signed_mode), .value(divisor), .mag(dvs_mag_c), .neg(dvs_neg_c)
  );

  assign chain[0] = acc;
  for (genvar g = 0; g < UNROLL; g++) begin : g_step
    div_restore_step #(.W(W)) u_step (
      .acc_i(chain[g]), .dvs_i(dvs_mag), .acc_o(chain[g+1])
    );
  end

  div_sign_fix #(.W(W)) u_fix (
    .q_mag(acc[W-1:0]), .r_mag(acc[2*W-1:W]),
    .q_neg(q_neg_r), .r_neg(r_neg_r),
    .q_out(q_fix), .r_out(r_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      step_cnt    <= '0;
      acc         <= '0;
      dvs_mag     <= '0;
      q_neg_r     <= 1'b0;
      r_neg_r     <= 1'b0;
      dz_r        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            acc      <= {{W{1'b0}}, dvd_mag_c};
            dvs_mag  <= dvs_mag_c;
            q_neg_r  <= dvd_neg_c ^ dvs_neg_c;
            r_neg_r  <= dvd_neg_c;
            dz_r     <= (divisor == '0);
            step_cnt <= '0;
            busy     <= 1'b1;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc      <= chain[UNROLL];
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) state <= ST_FINISH;
        end
        ST_FINISH: begin
          quotient    <= q_fix;
          remainder   <= r_fix;
          div_by_zero <= dz_r;
          done        <= 1'b1;
          busy        <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W      = 32,
  parameter int UNROLL = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero
);
  localparam int ITER = W / UNROLL;
  localparam int KW   = $clog2(ITER + 3) + 1;

  logic [KW-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (start && !busy) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst) done |-> (run_cnt == KW'(ITER + 1)));
  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind restoring_divider div_checker #(.W(W), .UNROLL(UNROLL)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
);

// File: tb/restoring_divider_test.sv
module restoring_divider_test;
  localparam int W    = 5;
  localparam int FULL = 1 << W;
  localparam int HALF = 1 << (W - 1);
  localparam int LAT  = W + 2;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  restoring_divider #(.W(W), .UNROLL(1)) uut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int a, input int b, input bit sm,
                                output logic [W-1:0] eq, output logic [W-1:0] er,
                                output bit edz);
    int sa, sb, q, r;
    edz = (b == 0);
    if (!sm) begin
      if (b == 0) begin eq = ONES; er = W'(a); end
      else begin eq = W'(a / b); er = W'(a % b); end
    end else begin
      sa = (a >= HALF) ? a - FULL : a;
      sb = (b >= HALF) ? b - FULL : b;
      if (b == 0) begin
        eq = (sa < 0) ? W'(1) : ONES;
        er = W'(a);
      end else begin
        q = sa / sb;
        r = sa % sb;
        eq = q[W-1:0];
        er = r[W-1:0];
      end
    end
  endfunction

  task automatic launch(input int a, input int b, input bit sm);
    @(negedge clk);
    dividend = W'(a); divisor = W'(b); signed_mode = sm; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // returns edge count with the accepting edge as 1; ends at posedge+1 with done seen
  task automatic wait_done(input int first, output int edges);
    edges = first;
    while (!done && edges < 200) begin
      @(posedge clk); #1;
      edges++;
    end
  endtask

  task automatic check_result(input string tag, input int a, input int b, input bit sm);
    logic [W-1:0] eq, er;
    bit edz;
    model(a, b, sm, eq, er, edz);
    chk({tag, " quotient"}, int'(quotient), int'(eq));
    chk({tag, " remainder"}, int'(remainder), int'(er));
    chk({tag, " R6 flag"}, int'(div_by_zero), int'(edz));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int edges;
    logic [W-1:0] hq, hr;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 quotient", int'(quotient), 0);
    chk("R1 remainder", int'(remainder), 0);
    chk("R1 flag", int'(div_by_zero), 0);

    // exhaustive sweep in both modes
    for (int sm = 0; sm < 2; sm++) begin
      for (int a = 0; a < FULL; a++) begin
        for (int b = 0; b < FULL; b++) begin
          if (b == 0) tag = "R6";
          else if (sm == 1 && a == HALF && b == FULL - 1) tag = "R5";
          else if (sm == 1) tag = "R3 R4";
          else tag = "R2";
          launch(a, b, sm[0]);
          chk("R7 busy after accept", int'(busy), 1);
          wait_done(1, edges);
          chk("R7 latency", edges, LAT);
          chk("R7 busy low at done", int'(busy), 0);
          check_result(tag, a, b, sm[0]);
          hq = quotient; hr = remainder;
          @(posedge clk); #1;
          chk("R7 single pulse", int'(done), 0);
          chk("R9 hold quotient", int'(quotient), int'(hq));
          chk("R9 hold remainder", int'(remainder), int'(hr));
        end
      end
    end

    // R8: start with other operands while busy is ignored
    launch(13, 3, 1'b0);
    hq = quotient; hr = remainder;
    @(posedge clk); #1;
    @(negedge clk);
    dividend = W'(7); divisor = W'(2); signed_mode = 1'b1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R9 held during run", int'(quotient), int'(hq));
    chk("R9 remainder held during run", int'(remainder), int'(hr));
    wait_done(3, edges);
    chk("R8 latency unchanged", edges, LAT);
    check_result("R8", 13, 3, 1'b0);
    // start raised in the finish cycle (busy still high) is ignored too
    launch(22, 5, 1'b0);
    wait_done(1, edges);
    check_result("R8 pre", 22, 5, 1'b0);
    @(posedge clk); #1;

    launch(27, 4, 1'b0);
    repeat (W) begin @(posedge clk); #1; end
    chk("R8 in finish cycle busy", int'(busy), 1);
    @(negedge clk);
    dividend = W'(9); divisor = W'(2); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R8 done after finish start", int'(done), 1);
    check_result("R8 finish", 27, 4, 1'b0);
    @(posedge clk); #1;
    chk("R8 not accepted", int'(busy), 0);

    // R10: back-to-back start in the done cycle
    launch(20, 6, 1'b0);
    wait_done(1, edges);
    check_result("R10 first", 20, 6, 1'b0);
    dividend = W'(9); divisor = W'(4); signed_mode = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R10 accepted", int'(busy), 1);
    wait_done(1, edges);
    chk("R10 latency", edges, LAT);
    check_result("R10 second", 9, 4, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule